// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block watches the protection flags of a two-channel H-bridge output stage and decides when the bridges may switch. Over-current, over-voltage and thermal-shutdown flags form the trip condition. Any one of them forces the bridges into high impedance at once, through a purely combinational path, and it also pulls an active-low fault output down once the flag has been synchronized. Under-voltage also forces high impedance. It never latches, so the bridges come back by themselves when the supply recovers. A separate over-temperature warning flag drives an active-low warning output. This output fires before thermal shutdown and has no effect on switching.

The fault can be recovered in two ways, and the `auto_mode` input picks one at the moment of the trip. In latched mode the fault stays set until the tri-state control input makes a high-low-high excursion. In automatic mode a cycle counter replaces an external RC network. It holds the fault for a programmable number of cycles and then re-enables the bridges. If the cause is still present, the block trips again. It keeps cycling this way until the cause goes away, and a larger delay gives a lower retry rate. The bridges are also held in high impedance whenever the power-enable input is low or the tri-state control input is low.

Top module: `pfs_supervisor`

## Requirements
- R1: `bridge_hiz` is high in the same cycle, with no clock edge in between, whenever any of `oc_flag`, `ov_flag`, `ts_flag` or `uv_flag` is high, or `pwr_en` is low, or `tri_ctl` is low.
- R2: `bridge_hiz` is also high for as long as `fault_n` is low.
- R3: A high level on `oc_flag`, `ov_flag` or `ts_flag` that is present at a rising edge drives `fault_n` low after the third rising edge, counting that edge as the first (SYNC_STAGES+1 edges). `fault_n` is still high after the second edge.
- R4: When `auto_mode` is 0 at the trip, `fault_n` stays low after the flags clear. It goes high only once `tri_ctl` has been seen low after the trip and is then seen high again. That happens 3 rising edges after `tri_ctl` rises.
- R5: When `auto_mode` is 1 at the trip, `fault_n` stays low for exactly `retry_dly`+1 cycles. The value used is the one present at the trip edge. `fault_n` then goes high.
- R6: In automatic mode with a cause that stays present, `fault_n` goes high for one cycle after each retry delay and then low again. This repeats for as long as the cause lasts.
- R7: `twarn_n` goes low 3 rising edges after `tw_flag` rises and returns high 3 edges after it falls. `tw_flag` changes neither `fault_n` nor `bridge_hiz`.
- R8: During and after a synchronous reset, `fault_n` and `twarn_n` are 1 and no fault is latched.
- R9: `uv_flag` never changes `fault_n`. When it drops, `bridge_hiz` follows at once with no latching.
- R10: A low level on `pwr_en` does not clear a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oc_flag | input | 1 | Over-current flag, asynchronous, active high |
| ov_flag | input | 1 | Over-voltage flag, asynchronous, active high |
| ts_flag | input | 1 | Thermal-shutdown flag, asynchronous, active high |
| uv_flag | input | 1 | Under-voltage lockout flag, asynchronous, active high |
| tw_flag | input | 1 | Over-temperature warning flag, asynchronous, active high |
| pwr_en | input | 1 | Power enable; low holds the bridges off |
| tri_ctl | input | 1 | Tri-state control; low holds the bridges off, high-low-high clears a latched fault |
| auto_mode | input | 1 | Recovery policy at the trip: 0 latched, 1 automatic retry |
| retry_dly | input | DLY_W | Automatic-mode hold time in cycles, minus one |
| bridge_hiz | output | 1 | Combinational high-impedance command for both bridges |
| fault_n | output | 1 | Registered fault indication, active low |
| twarn_n | output | 1 | Registered thermal warning, active low |

## Verification
The bench aims at the exact trip edge. A design that skipped a synchronizer stage, or added one, would move `fault_n` by a cycle. It also targets the retry window: an off-by-one counter would hold the fault for `retry_dly` or `retry_dly`+2 cycles, and zero is one of the delays used. Latched faults are probed under flags that have already cleared and under a `pwr_en` pulse. A supervisor that released on the flags or on power-down would let the bridges switch early, and one that cleared on a bare rising edge of `tri_ctl` would release without the low phase. Persistent faults in automatic mode check that the loop keeps retrying rather than sticking. Long random runs with under-voltage and warning flags check that neither of them ever latches a fault.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LATCH = 2'd1,
    ST_RETRY = 2'd2
  } pfs_state_e;

  // bit positions in the synchronized flag vector
  localparam int unsigned SY_OC  = 0;
  localparam int unsigned SY_OV  = 1;
  localparam int unsigned SY_TS  = 2;
  localparam int unsigned SY_TW  = 3;
  localparam int unsigned SY_TRI = 4;
  localparam int unsigned SY_W   = 5;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int unsigned WIDTH   = 5,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[b]}};
      else     pipe <= (pipe << 1) | STAGES'(din[b]);
    end
    assign dout[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/pfs_clear_detect.sv
module pfs_clear_detect (
  input  logic clk,
  input  logic rst,
  input  logic armed,     // a latched fault is waiting for release
  input  logic tri_s,     // synchronized tri-state control
  output logic clear
);
  logic low_seen;

  always_ff @(posedge clk) begin
    if (rst || !armed) low_seen <= 1'b0;
    else if (!tri_s)   low_seen <= 1'b1;
  end

  assign clear = armed && low_seen && tri_s;
endmodule

// File: rtl/pfs_retry_timer.sv
module pfs_retry_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] dly,
  input  logic             active,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= dly;
    else if (active && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = active && (cnt == '0);
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DLY_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oc_flag,
  input  logic             ov_flag,
  input  logic             ts_flag,
  input  logic             uv_flag,
  input  logic             tw_flag,
  input  logic             pwr_en,
  input  logic             tri_ctl,
  input  logic             auto_mode,
  input  logic [DLY_W-1:0] retry_dly,
  output logic             bridge_hiz,
  output logic             fault_n,
  output logic             twarn_n
);
  localparam logic [SY_W-1:0] SY_RST = SY_W'(1) << SY_TRI;

  logic [SY_W-1:0] raw_vec, syn_vec;
  logic            fault_s, clr_pulse, tmr_done, tmr_load;
  logic            fault_q, twarn_q;
  pfs_state_e      state_q, state_d;

  always_comb begin
    raw_vec         = '0;
    raw_vec[SY_OC]  = oc_flag;
    raw_vec[SY_OV]  = ov_flag;
    raw_vec[SY_TS]  = ts_flag;
    raw_vec[SY_TW]  = tw_flag;
    raw_vec[SY_TRI] = tri_ctl;
  end

  pfs_sync #(.WIDTH(SY_W), .STAGES(SYNC_STAGES), .RST_VAL(SY_RST)) u_sync (
    .clk(clk), .rst(rst), .din(raw_vec), .dout(syn_vec)
  );

  assign fault_s = syn_vec[SY_OC] | syn_vec[SY_OV] | syn_vec[SY_TS];

  pfs_clear_detect u_clr (
    .clk(clk), .rst(rst), .armed(state_q == ST_LATCH),
    .tri_s(syn_vec[SY_TRI]), .clear(clr_pulse)
  );

  assign tmr_load = (state_q == ST_RUN) && fault_s && auto_mode;

  pfs_retry_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .dly(retry_dly),
    .active(state_q == ST_RETRY), .done(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (fault_s) state_d = auto_mode ? ST_RETRY : ST_LATCH;
      ST_LATCH: if (clr_pulse) state_d = ST_RUN;
      ST_RETRY: if (tmr_done) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      fault_q <= 1'b1;
      twarn_q <= 1'b1;
    end else begin
      state_q <= state_d;
      fault_q <= (state_d == ST_RUN);
      twarn_q <= ~syn_vec[SY_TW];
    end
  end

  // unclocked shutdown path straight from the raw flags
  assign bridge_hiz = oc_flag | ov_flag | ts_flag | uv_flag | ~pwr_en | ~tri_ctl
                    | (state_q != ST_RUN);
  assign fault_n = fault_q;
  assign twarn_n = twarn_q;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
  import pfs_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             oc_flag,
  input logic             ov_flag,
  input logic             ts_flag,
  input logic             uv_flag,
  input logic             pwr_en,
  input logic             tri_ctl,
  input logic [DLY_W-1:0] retry_dly,
  input logic             bridge_hiz,
  input logic             fault_n,
  input logic             twarn_n,
  input logic             fault_s,
  input logic             tw_s,
  input logic             clr,
  input pfs_state_e       st
);
  logic [DLY_W:0]   wait_cnt;
  logic [DLY_W-1:0] cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      cap      <= '0;
    end else begin
      wait_cnt <= (st == ST_RETRY) ? wait_cnt + 1'b1 : '0;
      if (st == ST_RUN) cap <= retry_dly;
    end
  end

  assert_hiz_flags_R1: assert property (@(posedge clk) disable iff (rst)
    (oc_flag | ov_flag | ts_flag | uv_flag | !pwr_en | !tri_ctl) |-> bridge_hiz);

  assert_hiz_tripped_R2: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> bridge_hiz);

  assert_fault_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> $past(fault_s));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH && !clr) |=> !fault_n);

  assert_retry_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RETRY) |-> (wait_cnt <= {1'b0, cap}));

  assert_warn_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(twarn_n) |-> $past(tw_s));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (fault_n && twarn_n));
endmodule

bind pfs_supervisor pfs_checker #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .oc_flag(oc_flag), .ov_flag(ov_flag), .ts_flag(ts_flag),
  .uv_flag(uv_flag), .pwr_en(pwr_en), .tri_ctl(tri_ctl), .retry_dly(retry_dly),
  .bridge_hiz(bridge_hiz), .fault_n(fault_n), .twarn_n(twarn_n),
  .fault_s(fault_s), .tw_s(syn_vec[pfs_pkg::SY_TW]), .clr(clr_pulse), .st(state_q)
);

// File: tb/sim_pfs_supervisor.sv
module sim_pfs_supervisor;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic oc = 0, ov = 0, ts = 0, uv = 0, tw = 0, pwr = 1, tri_c = 1, amode = 0;
  logic [DW-1:0] dly = '0;
  logic hiz, fn, twn;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  pfs_supervisor #(.SYNC_STAGES(2), .DLY_W(DW)) u0 (
    .clk(clk), .rst(rst), .oc_flag(oc), .ov_flag(ov), .ts_flag(ts), .uv_flag(uv),
    .tw_flag(tw), .pwr_en(pwr), .tri_ctl(tri_c), .auto_mode(amode), .retry_dly(dly),
    .bridge_hiz(hiz), .fault_n(fn), .twarn_n(twn)
  );

  // reference model built from the requirements (0 run, 1 latched, 2 retry)
  logic [4:0] m1, m2;
  int         mst;
  logic       mlow, mtw;
  logic [DW-1:0] mcnt;

  always @(posedge clk) begin
    if (rst) begin
      m1 <= 5'b10000; m2 <= 5'b10000; mst <= 0; mlow <= 0; mcnt <= '0; mtw <= 1;
    end else begin
      m1  <= {tri_c, tw, ts, ov, oc};
      m2  <= m1;
      mtw <= ~m2[3];
      if (mst != 1) mlow <= 0; else if (!m2[4]) mlow <= 1;
      case (mst)
        0: if (m2[0] | m2[1] | m2[2]) begin
             if (amode) begin mst <= 2; mcnt <= dly; end else mst <= 1;
           end
        1: if (mlow && m2[4]) mst <= 0;
        default: if (mcnt == '0) mst <= 0; else mcnt <= mcnt - 1'b1;
      endcase
    end
  end

  function automatic logic exp_hiz();
    return oc | ov | ts | uv | ~pwr | ~tri_c | (mst != 0);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int rises;
    logic prev;
    void'($urandom(32'd2024));
    cyc(4);
    rst = 0;
    cyc(1);
    // R8 reset state
    chk("R8 fault_n", fn, 1'b1);
    chk("R8 twarn_n", twn, 1'b1);
    chk("R8 hiz", hiz, 1'b0);

    // R1 and R3: latched trip on over-current
    amode = 0;
    oc = 1; #1;
    chk("R1 hiz same cycle", hiz, 1'b1);
    cyc(2);
    chk("R3 not yet", fn, 1'b1);
    cyc(1);
    chk("R3 tripped", fn, 1'b0);
    oc = 0;
    cyc(8);
    chk("R4 held after flags clear", fn, 1'b0);
    chk("R2 hiz while tripped", hiz, 1'b1);
    // R10 power-down pulse does not release
    pwr = 0; cyc(4); pwr = 1; cyc(4);
    chk("R10 pwr_en pulse no release", fn, 1'b0);
    // R4 tri-state high-low-high
    tri_c = 0; cyc(4);
    chk("R4 low phase still latched", fn, 1'b0);
    tri_c = 1; cyc(2);
    chk("R4 before release edge", fn, 1'b0);
    cyc(1);
    chk("R4 released", fn, 1'b1);
    chk("R4 hiz off", hiz, 1'b0);

    // R5 automatic single retry, delay 5
    amode = 1; dly = 16'd5;
    ov = 1; cyc(1); ov = 0;
    cyc(2);
    begin
      int lows = 0;
      for (int i = 0; i < 12; i++) begin
        if (!fn) lows++;
        cyc(1);
      end
      chk("R5 low length 6", lows == 6, 1'b1);
    end
    // R5 zero delay
    dly = 16'd0;
    ov = 1; cyc(1); ov = 0;
    cyc(2);
    chk("R5 zero delay low", fn, 1'b0);
    cyc(1);
    chk("R5 zero delay back", fn, 1'b1);

    // R6 persistent fault keeps retrying
    dly = 16'd2; ts = 1;
    cyc(4);
    rises = 0; prev = fn;
    for (int i = 0; i < 24; i++) begin
      cyc(1);
      if (fn && !prev) rises++;
      prev = fn;
    end
    chk("R6 repeated retries", rises >= 5, 1'b1);
    ts = 0; cyc(8);
    chk("R6 settles after cause gone", fn, 1'b1);

    // R7 warning
    tw = 1; cyc(2);
    chk("R7 warn not yet", twn, 1'b1);
    cyc(1);
    chk("R7 warn low", twn, 1'b0);
    chk("R7 no hiz", hiz, 1'b0);
    cyc(4);
    chk("R7 no fault", fn, 1'b1);
    tw = 0; cyc(3);
    chk("R7 warn released", twn, 1'b1);

    // R9 under-voltage
    uv = 1; #1;
    chk("R9 hiz on", hiz, 1'b1);
    cyc(8);
    chk("R9 no fault", fn, 1'b1);
    uv = 0; #1;
    chk("R9 hiz off at once", hiz, 1'b0);

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      chk("R3/R4/R5/R6 fault_n model", fn, (mst == 0));
      chk("R7 twarn_n model", twn, mtw);
      if ($urandom % 60 == 0) oc = ~oc;
      if ($urandom % 90 == 0) ov = ~ov;
      if ($urandom % 120 == 0) ts = ~ts;
      if ($urandom % 50 == 0) uv = ~uv;
      if ($urandom % 40 == 0) tw = ~tw;
      if ($urandom % 100 == 0) pwr = ~pwr;
      if ($urandom % 12 == 0) tri_c = ~tri_c;
      if ($urandom % 150 == 0) amode = ~amode;
      if ($urandom % 80 == 0) dly = DW'($urandom % 12);
      #1;
      chk("R1/R2/R9 hiz model", hiz, exp_hiz());
    end
    finish_run();
  end
endmodule